// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual address into a physical address by walking a two-level page table in memory. It serves a segment that is set to page mode. The translator hands it the base address of the page directory and the virtual address over a valid/ready request. The walker then reads the directory entry and, if that entry is valid, the page table entry. It returns either the physical address or a fault as a one-cycle response.

The page is 8 KB. Address bits 31:24 select one of 256 directory entries, and each entry covers 16 MB. Bits 23:13 select one of 2048 table entries, and bits 12:0 are the byte offset. There is no middle level, so a directory entry points straight at a page table. Every entry is 4 bytes wide and carries a valid flag in bit 0. The memory side has one read in flight at most. A read is offered with valid/ready and its data returns later with a strobe.

Top module: `walk2l`

## Requirements
- R1: While reset is asserted and right after it, `reqReady` is 1 and `rspValid` and `memRdValid` are 0.
- R2: A request is taken only while the walker is idle (`reqReady` high). While a walk is in progress `reqReady` is 0, and a request presented then has no effect on the walk or on the reads it makes.
- R3: A virtual address in the first page (bits 31:13 all zero) gives a fault response in the cycle after acceptance, and no memory read is made.
- R4: The first read goes to directory base + 4 × address bits 31:24. For 0xD004000C this index is 0xD0.
- R5: A directory entry with bit 0 clear ends the walk with a fault, and no second read is issued.
- R6: The second read goes to {directory entry bits 31:13, address bits 23:13, 2'b00}. For 0xD004000C the table index is 0x020.
- R7: A page table entry with bit 0 clear ends the walk with a fault.
- R8: A walk that succeeds returns `rspFault` = 0 and `rspPaddr` = {table entry bits 31:13, address bits 12:0}. On a fault `rspPaddr` is 0.
- R9: At most one read is outstanding. `memRdValid` stays high with a stable `memRdAddr` until `memRdReady` is seen. No further read starts until `memRspValid` returns the data.
- R10: `rspValid` is a single-cycle pulse. `reqReady` is high again in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker idle, request taken this cycle |
| reqVaddr | input | 32 | Virtual address to translate |
| reqDirBase | input | 32 | Page directory base address |
| rspValid | output | 1 | Response pulse |
| rspFault | output | 1 | Response is a fault |
| rspPaddr | output | 32 | Physical address, 0 on fault |
| memRdValid | output | 1 | Read request to memory |
| memRdReady | input | 1 | Memory accepts the read |
| memRdAddr | output | 32 | Byte address of the entry to read |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Entry returned by memory |

## Verification
The hardest case to reach is a request that arrives while a walk is in progress, and in particular one that would fault at once if it were taken. The bench holds a first-page address on the request port for the whole of a walk that memory stalls. It then checks that the response and the logged read addresses still belong to the first walk. A bench memory model with a settable delay holds back `memRdReady` and the returned data. This keeps the read request pending over several cycles, so the address-hold and single-outstanding rules are exercised and not only met by chance.

// File: rtl/walk2l_pkg.sv
package walk2l_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR,
    ST_TBL,
    ST_DONE,
    ST_FAULT
  } walkState_t;

  typedef struct packed {
    logic loadReq;    // capture request fields
    logic loadEntry;  // capture returned entry
    logic selTbl;     // read address from table level
    logic showPaddr;  // drive translated address on response
  } walkStrobes_t;

endpackage

// File: rtl/walk2l_ctrl.sv
module walk2l_ctrl
  import walk2l_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqNull,
  output logic         reqReady,
  output logic         memRdValid,
  input  logic         memRdReady,
  input  logic         memRspValid,
  input  logic         entryValid,
  output logic         rspValid,
  output logic         rspFault,
  output walkStrobes_t strobes
);

  walkState_t state, stateNext;
  logic issued;
  logic inRead;
  logic rspTaken;

  assign inRead   = (state == ST_DIR) || (state == ST_TBL);
  assign rspTaken = inRead && issued && memRspValid;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (reqValid) stateNext = reqNull ? ST_FAULT : ST_DIR;
      ST_DIR:   if (rspTaken) stateNext = entryValid ? ST_TBL : ST_FAULT;
      ST_TBL:   if (rspTaken) stateNext = entryValid ? ST_DONE : ST_FAULT;
      ST_DONE:  stateNext = ST_IDLE;
      ST_FAULT: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      issued <= 1'b0;
    end else begin
      state <= stateNext;
      if (memRdValid && memRdReady) issued <= 1'b1;
      else if (rspTaken)           issued <= 1'b0;
    end
  end

  assign reqReady   = (state == ST_IDLE);
  assign memRdValid = inRead && !issued;
  assign rspValid   = (state == ST_DONE) || (state == ST_FAULT);
  assign rspFault   = (state == ST_FAULT);

  always_comb begin
    strobes           = '0;
    strobes.loadReq   = (state == ST_IDLE) && reqValid;
    strobes.loadEntry = rspTaken;
    strobes.selTbl    = (state == ST_TBL);
    strobes.showPaddr = (state == ST_DONE);
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    $past(memRdValid && memRdReady) |-> !memRdValid) else $error("second read while one pending"); // R9

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !rspValid && !memRdValid) else $error("ready while busy"); // R2

  AST_BAD_DIR_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DIR && rspTaken && !entryValid) |=> rspValid && rspFault && !memRdValid) else $error("walk went on after bad directory entry"); // R5

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid && reqReady) else $error("response longer than one cycle"); // R10

endmodule

// File: rtl/walk2l_datapath.sv
module walk2l_datapath
  import walk2l_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 13,
  parameter int TBL_W  = 11,
  parameter int ENT_LG = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobes_t      strobes,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic [ADDR_W-1:0] reqDirBase,
  input  logic [ADDR_W-1:0] memRspData,
  input  logic              memRdValid,
  input  logic              memRdReady,
  output logic              reqNull,
  output logic              entryValid,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic [ADDR_W-1:0] rspPaddr
);

  localparam int DIR_W  = ADDR_W - OFF_W - TBL_W;
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam int DIR_LO = OFF_W + TBL_W;

  logic [ADDR_W-1:0] vaddrQ;
  logic [ADDR_W-1:0] baseQ;
  logic [ADDR_W-1:0] entryQ;
  logic [ADDR_W-1:0] dirAddr;
  logic [ADDR_W-1:0] tblAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaddrQ <= '0;
      baseQ  <= '0;
      entryQ <= '0;
    end else begin
      if (strobes.loadReq) begin
        vaddrQ <= reqVaddr;
        baseQ  <= reqDirBase;
      end
      if (strobes.loadEntry) entryQ <= memRspData;
    end
  end

  assign reqNull    = (reqVaddr[ADDR_W-1:OFF_W] == '0);
  assign entryValid = memRspData[0];

  assign dirAddr = baseQ + {{(ADDR_W-DIR_W-ENT_LG){1'b0}}, vaddrQ[ADDR_W-1:DIR_LO], {ENT_LG{1'b0}}};

  generate
    if (TBL_W + ENT_LG == OFF_W) begin : g_pageTable
      assign tblAddr = {entryQ[ADDR_W-1:OFF_W], vaddrQ[DIR_LO-1:OFF_W], {ENT_LG{1'b0}}};
    end else begin : g_addTable
      assign tblAddr = {entryQ[ADDR_W-1:OFF_W], {OFF_W{1'b0}}}
                     + {{(ADDR_W-TBL_W-ENT_LG){1'b0}}, vaddrQ[DIR_LO-1:OFF_W], {ENT_LG{1'b0}}};
    end
  endgenerate

  assign memRdAddr = strobes.selTbl ? tblAddr : dirAddr;
  assign rspPaddr  = strobes.showPaddr ? {entryQ[ADDR_W-1:OFF_W], vaddrQ[OFF_W-1:0]} : '0;

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memRdValid && !memRdReady) |=> memRdValid && $stable(memRdAddr)) else $error("read address moved while pending"); // R9

  AST_ENTRY_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    (memRdValid && $past(strobes.loadReq) && reqDirBase[ENT_LG-1:0] == '0 && $stable(reqDirBase))
      |-> memRdAddr[ENT_LG-1:0] == '0) else $error("directory read misaligned"); // R4

  initial begin
    if (PAGE_W <= 0 || DIR_W <= 0) $error("address split does not fit");
  end

endmodule

// File: rtl/walk2l.sv
module walk2l
  import walk2l_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 13,
  parameter int TBL_W  = 11,
  parameter int ENT_LG = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic [ADDR_W-1:0] reqDirBase,
  output logic              rspValid,
  output logic              rspFault,
  output logic [ADDR_W-1:0] rspPaddr,
  output logic              memRdValid,
  input  logic              memRdReady,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic              memRspValid,
  input  logic [ADDR_W-1:0] memRspData
);

  walkStrobes_t strobes;
  logic reqNull;
  logic entryValid;

  walk2l_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqNull    (reqNull),
    .reqReady   (reqReady),
    .memRdValid (memRdValid),
    .memRdReady (memRdReady),
    .memRspValid(memRspValid),
    .entryValid (entryValid),
    .rspValid   (rspValid),
    .rspFault   (rspFault),
    .strobes    (strobes)
  );

  walk2l_datapath #(
    .ADDR_W(ADDR_W),
    .OFF_W (OFF_W),
    .TBL_W (TBL_W),
    .ENT_LG(ENT_LG)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .reqVaddr   (reqVaddr),
    .reqDirBase (reqDirBase),
    .memRspData (memRspData),
    .memRdValid (memRdValid),
    .memRdReady (memRdReady),
    .reqNull    (reqNull),
    .entryValid (entryValid),
    .memRdAddr  (memRdAddr),
    .rspPaddr   (rspPaddr)
  );

  AST_NULL_FAULTS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqVaddr[ADDR_W-1:OFF_W] == '0) |=> rspValid && rspFault && !memRdValid) else $error("first page not faulted"); // R3

  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault) |-> rspPaddr == '0) else $error("fault response carries address"); // R8

endmodule

// File: tb/walk2l_bench.sv
module walk2l_bench;

  typedef struct packed {
    logic [31:0] va;
    logic [31:0] base;
    logic [31:0] dirEnt;
    logic [31:0] tblEnt;
    logic        fault;
    logic [1:0]  reads;
    logic [1:0]  stall;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{32'hD004000C, 32'h00100000, 32'h00042001, 32'h1234A001, 1'b0, 2'd2, 2'd0},
    '{32'h40002000, 32'h00200000, 32'h00042000, 32'h00000001, 1'b1, 2'd1, 2'd1},
    '{32'h00800000, 32'h00300000, 32'h0007E001, 32'h55554000, 1'b1, 2'd2, 2'd2},
    '{32'h00001FFF, 32'h00100000, 32'h00042001, 32'h00006001, 1'b1, 2'd0, 2'd0},
    '{32'h00002000, 32'h00400000, 32'h00010001, 32'hABCDE001, 1'b0, 2'd2, 2'd1},
    '{32'hFFFFFFFF, 32'hFFFFFC00, 32'hFFFFE001, 32'hFFFFE001, 1'b0, 2'd2, 2'd3}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVaddr = '0;
  logic [31:0] reqDirBase = '0;
  logic        rspValid;
  logic        rspFault;
  logic [31:0] rspPaddr;
  logic        memRdValid;
  logic        memRdReady = 1'b0;
  logic [31:0] memRdAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;

  int total = 0;
  int bad = 0;
  vec_t curVec;
  int readCnt = 0;
  logic [31:0] readLog [4];
  bit holdBad = 1'b0;

  always #2.5 clk = ~clk;

  walk2l u_walk2l (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVaddr(reqVaddr), .reqDirBase(reqDirBase), .rspValid(rspValid),
    .rspFault(rspFault), .rspPaddr(rspPaddr), .memRdValid(memRdValid),
    .memRdReady(memRdReady), .memRdAddr(memRdAddr), .memRspValid(memRspValid),
    .memRspData(memRspData)
  );

  function automatic logic [31:0] dirAddrOf(vec_t v);
    return v.base + {22'd0, v.va[31:24], 2'b00};
  endfunction

  function automatic logic [31:0] tblAddrOf(vec_t v);
    return {v.dirEnt[31:13], v.va[23:13], 2'b00};
  endfunction

  function automatic logic [31:0] lookup(logic [31:0] a);
    if (a == dirAddrOf(curVec)) return curVec.dirEnt;
    if (a == tblAddrOf(curVec)) return curVec.tblEnt;
    return 32'hDEADBEE0;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: one read at a time, with a settable delay
  initial begin
    forever begin
      @(negedge clk);
      if (memRdValid) begin
        automatic logic [31:0] first = memRdAddr;
        repeat (int'(curVec.stall)) @(negedge clk);
        if (!memRdValid || memRdAddr != first) holdBad = 1'b1;
        memRdReady = 1'b1;
        @(negedge clk);
        memRdReady = 1'b0;
        if (readCnt < 4) readLog[readCnt] = first;
        readCnt++;
        repeat (int'(curVec.stall)) @(negedge clk);
        if (memRdValid) holdBad = 1'b1;
        memRspData  = lookup(first);
        memRspValid = 1'b1;
        @(negedge clk);
        memRspValid = 1'b0;
      end
    end
  end

  task automatic waitRsp(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 80; i++) begin
      if (rspValid) begin
        seen = 1'b1;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic checkResult(vec_t v, bit seen);
    logic [31:0] expPa;
    expPa = v.fault ? 32'h0 : {v.tblEnt[31:13], v.va[12:0]};
    check(seen, "R8 response seen", {31'd0, seen}, 32'd1);
    check(rspFault == v.fault, v.fault ? "R5/R7 fault flag" : "R8 fault flag", {31'd0, rspFault}, {31'd0, v.fault});
    check(rspPaddr == expPa, "R8 paddr", rspPaddr, expPa);
    check(readCnt == int'(v.reads), "R3/R5 read count", readCnt, {30'd0, v.reads});
    if (v.reads >= 2'd1) check(readLog[0] == dirAddrOf(v), "R4 directory address", readLog[0], dirAddrOf(v));
    if (v.reads == 2'd2) check(readLog[1] == tblAddrOf(v), "R6 table address", readLog[1], tblAddrOf(v));
    check(!holdBad, "R9 read hold / single outstanding", {31'd0, holdBad}, 32'd0);
    @(negedge clk);
    check(!rspValid && reqReady, "R10 pulse then ready", {30'd0, rspValid, reqReady}, 32'd1);
  endtask

  task automatic runVec(vec_t v);
    bit seen;
    curVec  = v;
    readCnt = 0;
    holdBad = 1'b0;
    reqVaddr = v.va;
    reqDirBase = v.base;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    if (v.reads == 2'd0) check(rspValid && rspFault, "R3 fault next cycle", {30'd0, rspValid, rspFault}, 32'd3);
    waitRsp(seen);
    checkResult(v, seen);
  endtask

  task automatic runAll;
    bit seen;
    // R1: reset state
    @(negedge clk);
    check(reqReady && !rspValid && !memRdValid, "R1 in reset", {29'd0, reqReady, rspValid, memRdValid}, 32'h4);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady && !rspValid && !memRdValid, "R1 after reset", {29'd0, reqReady, rspValid, memRdValid}, 32'h4);

    // R4 / R6 worked example
    check(dirAddrOf(VECS[0]) == 32'h00100340, "R4 example index", dirAddrOf(VECS[0]), 32'h00100340);
    check(tblAddrOf(VECS[0]) == 32'h00042080, "R6 example index", tblAddrOf(VECS[0]), 32'h00042080);

    for (int k = 0; k < NVEC; k++) runVec(VECS[k]);

    // R2: request held during a slow walk is ignored
    curVec  = VECS[5];
    readCnt = 0;
    holdBad = 1'b0;
    reqVaddr = VECS[5].va;
    reqDirBase = VECS[5].base;
    reqValid = 1'b1;
    @(negedge clk);
    reqVaddr = 32'h00000010;
    reqDirBase = 32'h00900000;
    for (int i = 0; i < 6; i++) begin
      check(!reqReady, "R2 busy not ready", {31'd0, reqReady}, 32'd0);
      @(negedge clk);
    end
    waitRsp(seen);
    reqValid = 1'b0;
    checkResult(VECS[5], seen);
    @(negedge clk);
    check(!rspValid && !memRdValid, "R2 no extra walk", {30'd0, rspValid, memRdValid}, 32'd0);
  endtask

  initial begin
    rstN = 1'b0;
    curVec = VECS[0];
    repeat (3) @(posedge clk);
    fork
      runAll();
      begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule